// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the word address for four-beat bursts in a synchronous burst memory. A capture on either of two address strobes registers a new base address. From then on, the two lowest address bits step through a four-beat sequence each time the active-low advance input is sampled low on a rising clock edge. The upper address bits are passed through unchanged from the base for as long as the burst lasts.

A static order input selects one of two sequences. The linear order counts the low bits upward modulo four from the base. The interleaved order XORs the base with the beat index. A high advance input suspends the burst and holds the address. A new capture ends any burst in progress and restarts it at the new base.

Top module: `burst_addr_seq`

## Requirements
- R1: After a synchronous reset (`rst` high at a rising edge), `addr_o` is all zeros.
- R2: A rising edge with `cap_a_i` or `cap_b_i` high registers `base_i`, and `addr_o` equals `base_i` after that edge.
- R3: With `order_i` = 0 (linear), after k advances since the last capture the low two bits of `addr_o` equal (base low bits + k) mod 4.
- R4: With `order_i` = 1 (interleaved), after k advances the low two bits of `addr_o` equal base low bits XOR (k mod 4); for example, base 1 gives 1, 0, 3, 2.
- R5: A rising edge with no capture and `adv_n_i` high leaves `addr_o` unchanged (suspend).
- R6: Without a capture, bits [ADDR_W-1:2] of `addr_o` never change.
- R7: When a capture and an advance (`adv_n_i` low) fall on the same edge, the capture wins and `addr_o` equals `base_i` after that edge.
- R8: After four advances the address returns to the base address, in either order.
- R9: A capture during a burst ends that burst, and the next sequence starts from the new base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_a_i | input | 1 | First address strobe, active high, captures `base_i` |
| cap_b_i | input | 1 | Second address strobe, active high, captures `base_i` |
| base_i | input | ADDR_W | Base address to capture |
| adv_n_i | input | 1 | Advance, active low; high suspends the burst |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_o | output | ADDR_W | Current burst address |

## Verification
The bench builds the block with ADDR_W = 10. This keeps the upper field small enough that random bases revisit many upper patterns, while still leaving eight bits that must stay frozen throughout each burst. Both orders are run from all four low-bit base values. Random runs of advances and suspends with frequent captures reach wrap-around, mid-burst restarts and same-edge capture-with-advance.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int LOW_W = 2;

    typedef logic [LOW_W-1:0] beat_t;

    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } burst_order_e;

    typedef struct packed {
        logic load;
        logic step;
    } seq_cmd_t;

    function automatic beat_t beat_low(input beat_t base_lo, input beat_t idx,
                                       input burst_order_e ord);
        beat_t r;
        if (ord == ORDER_INTERLEAVE) r = base_lo ^ idx;
        else                         r = beat_t'(base_lo + idx);
        return r;
    endfunction

    function automatic seq_cmd_t decode_cmd(input logic cap_a, input logic cap_b,
                                            input logic adv_n);
        seq_cmd_t c;
        c.load = cap_a | cap_b;
        c.step = ~(cap_a | cap_b) & ~adv_n;
        return c;
    endfunction

endpackage

// File: rtl/burst_step_ctr.sv
module burst_step_ctr
    import burst_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  seq_cmd_t cmd,
    output beat_t    idx_o
);
    beat_t idx_q;

    always_ff @(posedge clk) begin
        if (rst)           idx_q <= '0;
        else if (cmd.load) idx_q <= '0;
        else if (cmd.step) idx_q <= beat_t'(idx_q + beat_t'(1));
    end

    assign idx_o = idx_q;

    // R3 / R4: one advance moves the beat index by exactly one step
    a_r3_step_one: assert property (@(posedge clk) disable iff (rst)
        (!cmd.load && cmd.step) |=> idx_q == beat_t'($past(idx_q) + beat_t'(1)));

    // R5: suspend keeps the beat index
    a_r5_suspend_hold: assert property (@(posedge clk) disable iff (rst)
        (!cmd.load && !cmd.step) |=> $stable(idx_q));

    // R7: a capture restarts the index even with an advance pending
    a_r7_load_restart: assert property (@(posedge clk) disable iff (rst)
        cmd.load |=> idx_q == '0);
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_i,
    output logic [ADDR_W-1:0] base_o
);
    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst)       base_q <= '0;
        else if (load) base_q <= base_i;
    end

    assign base_o = base_q;

    // R2: a capture registers the presented base
    a_r2_capture: assert property (@(posedge clk) disable iff (rst)
        load |=> base_q == $past(base_i));
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] base_i,
    input  beat_t             idx_i,
    input  burst_order_e      order_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int HI_W = ADDR_W - LOW_W;

    beat_t low;
    assign low = beat_low(base_i[LOW_W-1:0], idx_i, order_i);

    generate
        if (HI_W > 0) begin : g_upper
            assign addr_o = {base_i[ADDR_W-1:LOW_W], low};
        end else begin : g_low_only
            assign addr_o = low[ADDR_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_a_i,
    input  logic              cap_b_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              adv_n_i,
    input  logic              order_i,
    output logic [ADDR_W-1:0] addr_o
);
    seq_cmd_t          cmd;
    beat_t             idx;
    logic [ADDR_W-1:0] base_q;
    burst_order_e      ord;

    assign cmd = decode_cmd(cap_a_i, cap_b_i, adv_n_i);
    assign ord = burst_order_e'(order_i);

    burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk    (clk),
        .rst    (rst),
        .load   (cmd.load),
        .base_i (base_i),
        .base_o (base_q)
    );

    burst_step_ctr u_ctr (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .idx_o (idx)
    );

    burst_addr_map #(.ADDR_W(ADDR_W)) u_map (
        .base_i  (base_q),
        .idx_i   (idx),
        .order_i (ord),
        .addr_o  (addr_o)
    );

    // R6: upper bits frozen while no capture occurs
    a_r6_upper_frozen: assert property (@(posedge clk) disable iff (rst)
        !cmd.load |=> addr_o[ADDR_W-1:LOW_W] == $past(addr_o[ADDR_W-1:LOW_W]));
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cap_a = 1'b0, cap_b = 1'b0, adv_n = 1'b1, order = 1'b0;
    logic [W-1:0] base = '0;
    logic [W-1:0] addr;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] m_base = '0;
    int           m_k = 0;

    burst_addr_seq #(.ADDR_W(W)) u_dut (
        .clk(clk), .rst(rst), .cap_a_i(cap_a), .cap_b_i(cap_b),
        .base_i(base), .adv_n_i(adv_n), .order_i(order), .addr_o(addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic logic [W-1:0] expect_addr(input logic [W-1:0] b, input int k,
                                                 input logic ord);
        logic [1:0] lo;
        if (ord) lo = b[1:0] ^ 2'(k % 4);
        else     lo = 2'((b[1:0] + k) % 4);
        return {b[W-1:2], lo};
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: addr actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, update model at edge, check at next negedge
    task automatic step(input logic ca, input logic cb, input logic [W-1:0] b,
                        input logic an, input logic ord, input string tag);
        logic [W-1:0] prev_hi;
        prev_hi = addr;
        cap_a = ca; cap_b = cb; base = b; adv_n = an; order = ord;
        @(posedge clk);
        if (ca || cb) begin m_base = b; m_k = 0; end
        else if (!an) m_k++;
        @(negedge clk);
        chk(tag, addr, expect_addr(m_base, m_k, ord));
        if (!(ca || cb)) chk("R6", {addr[W-1:2], 2'b00}, {prev_hi[W-1:2], 2'b00});
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        chk("R1", addr, '0);

        // R2: capture via each strobe
        step(1, 0, 10'h2A5, 1, 0, "R2");
        step(0, 1, 10'h1C3, 1, 0, "R2");
        // R3 + R8: linear from base low 1 : 2,3,0,1
        step(1, 0, 10'h0F1, 1, 0, "R2");
        for (int i = 0; i < 4; i++) step(0, 0, 10'h0, 0, 0, (i == 3) ? "R8" : "R3");
        // R4 + R8: interleaved base 1 -> 0,3,2,1
        step(0, 1, 10'h305, 1, 1, "R2");
        for (int i = 0; i < 4; i++) step(0, 0, 10'h0, 0, 1, (i == 3) ? "R8" : "R4");
        // R5: suspend mid burst
        step(0, 0, 10'h3FF, 0, 1, "R4");
        for (int i = 0; i < 3; i++) step(0, 0, 10'h155, 1, 1, "R5");
        // R7: capture with advance same edge
        step(1, 0, 10'h0AA, 0, 0, "R7");
        step(0, 0, 10'h0, 0, 0, "R3");
        // R9: restart mid burst at new base
        step(0, 1, 10'h233, 0, 1, "R9");
        step(0, 0, 10'h0, 0, 1, "R9");
        step(0, 0, 10'h0, 0, 1, "R9");

        // every low base in both orders
        for (int o = 0; o < 2; o++)
            for (int b = 0; b < 4; b++) begin
                step(1, 0, W'(10'h100 + b), 1, o[0], "R2");
                for (int i = 0; i < 5; i++) step(0, 0, 10'h0, 0, o[0], o ? "R4" : "R3");
            end

        // constrained random
        void'($urandom(32'd4242));
        begin
            logic ord_r;
            ord_r = 0;
            for (int n = 0; n < 3000; n++) begin
                logic ca, cb, an;
                logic [W-1:0] b;
                int r;
                r  = $urandom_range(0, 9);
                ca = (r == 0);
                cb = (r == 1);
                an = ($urandom_range(0, 2) == 0);
                b  = W'($urandom);
                if (ca || cb) ord_r = 1'($urandom);
                if (ca || cb)   step(ca, cb, b, an, ord_r, an ? "R2" : "R7");
                else if (an)    step(0, 0, b, 1, ord_r, "R5");
                else            step(0, 0, b, 0, ord_r, ord_r ? "R4" : "R3");
            end
        end

        // R1: reset mid burst clears address
        cap_a = 0; cap_b = 0; adv_n = 0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1", addr, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule